// File: doc/BRIEF.md
# Streaming Run Classifier and Feature Accumulator

This block is the front end of a single-pass connected-component analyser. It accepts a binary image in raster order, one pixel per clock, with no blanking between rows. It compares each pixel with its left neighbour to place it in one of four positions: a run begins, the pixel is inside a run, the pixel is the first background pixel after a run, or the pixel lies outside any run. Runs, not pixels, receive the labels. A run is a horizontal stretch of foreground pixels.

For every column, the block keeps a record of the row above. The record holds a foreground bit, a run-head bit and the provisional label of the run that began there. Two such records alternate row by row. The block reads one while it writes the other. A label written at the head column when a run closes therefore never collides with the per-pixel writes. From the record the block detects 4-connected overlap with the previous row. It also reports equivalence candidates, which arise when one run touches two runs above it. As the run is scanned, the block sums the pixel count, the column indices and the row indices. It emits a run-end record with those totals, the overlap flag, the last overlapped label from the row above and the run's own new label. A downstream label-translation stage consumes these records.

Top module: `run_scanner`

## Requirements
- R1: A foreground pixel whose left neighbour is background (the first pixel of a row always has a background left neighbour) begins a run. A background pixel whose left neighbour is foreground closes the run. evValid pulses exactly one clock after that closing pixel and at no other time, except as R3 describes.
- R2: The run-end record gives the run's pixel count in evCount and the sum of its column indices (0 = leftmost) in evSumCol.
- R3: A run that reaches the last column (COLS-1) ends at that pixel. evValid pulses one clock after it, and the totals include that pixel, so the record is out before the next row starts.
- R4: evOverlap is 1 exactly when some pixel of the run has a foreground pixel directly above it in the previous row. No run in the row that carries frameStart has overlap.
- R5: evPrevLabel is the previous-row label of the rightmost overlapped previous-row run, or 0 when evOverlap is 0.
- R6: evLabel numbers the runs of a row 1, 2, 3, … in the order they end, and the numbering restarts at every row. At most COLS/2 labels occur per row.
- R7: eqValid pulses one clock after a foreground pixel that meets three conditions: it is not the first pixel of its run, its run has already overlapped at an earlier column, and the pixel above it begins a previous-row run. eqLabelA is the last overlapped previous-row label and eqLabelB is the label of the run beginning above.
- R8: Pixels are accepted back to back across row boundaries. A clock with pixValid low changes no state and produces no evValid or eqValid.
- R9: After reset, evValid and eqValid are 0.
- R10: Row indices count from 0 on the pixel with frameStart and advance on each lineStart. evSumRow is the run's pixel count times its row index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pixValid | input | 1 | Pixel qualifier |
| pixData | input | 1 | Binary pixel, 1 = foreground |
| lineStart | input | 1 | Marks column 0 of a row |
| frameStart | input | 1 | Marks row 0 column 0 (given together with lineStart) |
| evValid | output | 1 | Run-end record valid |
| evCount | output | $clog2(COLS+1) | Pixels in the run |
| evSumCol | output | $clog2(COLS*(COLS-1)/2+1) | Sum of column indices |
| evSumRow | output | $clog2(COLS*(ROWS-1)+1) | Sum of row indices |
| evOverlap | output | 1 | Run touches the previous row |
| evPrevLabel | output | $clog2(COLS/2+1) | Last overlapped previous-row label |
| evLabel | output | $clog2(COLS/2+1) | New provisional label of the run |
| eqValid | output | 1 | Equivalence candidate valid |
| eqLabelA | output | $clog2(COLS/2+1) | Earlier overlapped previous-row label |
| eqLabelB | output | $clog2(COLS/2+1) | Previous-row label beginning above |

## Verification
Every result is due one clock after the pixel that causes it. A run-end record follows the first background pixel after the run, or the last-column pixel for an edge run. An equivalence candidate follows the pixel that triggers it. An idle clock yields nothing one clock later. The bench drives each pixel on a falling edge. At the next falling edge, just before it drives the following pixel, it compares both outputs with values its own run-level model predicts for the pixel just driven. No result can then be read one clock early or late without a mismatch.

// File: rtl/scan_pkg.sv
package scan_pkg;
  // Strobes from the control to the datapath, one set per clock.
  typedef struct packed {
    logic act;        // a pixel is accepted this clock
    logic fg;         // accepted pixel is foreground
    logic runBegin;   // left background, current foreground
    logic runInside;  // left foreground, current foreground
    logic tailAfter;  // left foreground, current background
    logic edgeEnd;    // foreground pixel in the last column
    logic lineStart;  // pixel is column 0
    logic firstRow;   // pixel is in row 0 of the frame
    logic bank;       // record bank written in this row
  } scanStrobe_t;
endpackage

// File: rtl/row_record.sv
module row_record #(
  parameter int COLS  = 16,
  parameter int LAB_W = 4,
  localparam int COL_W = $clog2(COLS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rdBank,
  input  logic [COL_W-1:0] rdCol,
  output logic             rdFg,
  output logic             rdStart,
  output logic [LAB_W-1:0] rdLabel,
  input  logic             pixWe,
  input  logic             wrBank,
  input  logic [COL_W-1:0] wrCol,
  input  logic             wrFg,
  input  logic             wrStart,
  input  logic             labWe,
  input  logic [COL_W-1:0] labCol,
  input  logic [LAB_W-1:0] labVal
);
  logic [1:0]       fgArr;
  logic [1:0]       stArr;
  logic [LAB_W-1:0] labArr [2];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [COLS-1:0]  fgBits;
    logic [COLS-1:0]  stBits;
    logic [LAB_W-1:0] labMem [COLS];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        fgBits <= '0;
        stBits <= '0;
      end else if (pixWe && (wrBank == 1'(b))) begin
        fgBits[wrCol] <= wrFg;
        stBits[wrCol] <= wrStart;
      end
    end

    // Separate write port for the head-column label at a run's close.
    always_ff @(posedge clk) begin
      if (labWe && (wrBank == 1'(b))) labMem[labCol] <= labVal;
    end

    assign fgArr[b]  = fgBits[rdCol];
    assign stArr[b]  = stBits[rdCol];
    assign labArr[b] = labMem[rdCol];
  end

  assign rdFg    = fgArr[rdBank];
  assign rdStart = stArr[rdBank];
  assign rdLabel = labArr[rdBank];
endmodule

// File: rtl/scan_ctrl.sv
module scan_ctrl
  import scan_pkg::*;
#(
  parameter int COLS = 16,
  parameter int ROWS = 16,
  localparam int COL_W = $clog2(COLS),
  localparam int CW1   = $clog2(COLS + 1),
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pixValid,
  input  logic             pixData,
  input  logic             lineStart,
  input  logic             frameStart,
  output scanStrobe_t      strb,
  output logic [COL_W-1:0] colIdx,
  output logic [ROW_W-1:0] rowIdx
);
  logic [CW1-1:0]   colReg, curCol;
  logic [ROW_W-1:0] rowReg, curRow;
  logic             prevPix, leftFg, outside;

  always_comb begin
    curCol = lineStart ? '0 : colReg;
    if (frameStart)     curRow = '0;
    else if (lineStart) curRow = rowReg + 1'b1;
    else                curRow = rowReg;
  end

  assign leftFg  = lineStart ? 1'b0 : prevPix;
  assign outside = pixValid & ~pixData & ~leftFg;

  always_comb begin
    strb.act       = pixValid;
    strb.fg        = pixValid & pixData;
    strb.runBegin  = pixValid & pixData & ~leftFg;
    strb.runInside = pixValid & pixData & leftFg;
    strb.tailAfter = pixValid & ~pixData & leftFg;
    strb.edgeEnd   = pixValid & pixData & (curCol == CW1'(COLS - 1));
    strb.lineStart = lineStart;
    strb.firstRow  = (curRow == '0);
    strb.bank      = curRow[0];
  end

  assign colIdx = curCol[COL_W-1:0];
  assign rowIdx = curRow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      colReg  <= '0;
      rowReg  <= '0;
      prevPix <= 1'b0;
    end else if (pixValid) begin
      colReg  <= curCol + 1'b1;
      rowReg  <= curRow;
      prevPix <= pixData;
    end
  end

  // Each accepted pixel falls in exactly one of the four positions.
  assert_one_class_R1: assert property (@(posedge clk) disable iff (!rstN)
    pixValid |-> $countones({strb.runBegin, strb.runInside, strb.tailAfter, outside}) == 1);

  // Rows are no longer than COLS pixels between line markers.
  assert_row_length_R8: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && !lineStart) |-> (colReg < CW1'(COLS)));
endmodule

// File: rtl/scan_datapath.sv
module scan_datapath
  import scan_pkg::*;
#(
  parameter int COLS = 16,
  parameter int ROWS = 16,
  localparam int COL_W = $clog2(COLS),
  localparam int ROW_W = $clog2(ROWS),
  localparam int LAB_W = $clog2(COLS / 2 + 1),
  localparam int CNT_W = $clog2(COLS + 1),
  localparam int SC_W  = $clog2(COLS * (COLS - 1) / 2 + 1),
  localparam int SR_W  = $clog2(COLS * (ROWS - 1) + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  scanStrobe_t      strb,
  input  logic [COL_W-1:0] colIdx,
  input  logic [ROW_W-1:0] rowIdx,
  output logic             evValid,
  output logic [CNT_W-1:0] evCount,
  output logic [SC_W-1:0]  evSumCol,
  output logic [SR_W-1:0]  evSumRow,
  output logic             evOverlap,
  output logic [LAB_W-1:0] evPrevLabel,
  output logic [LAB_W-1:0] evLabel,
  output logic             eqValid,
  output logic [LAB_W-1:0] eqLabelA,
  output logic [LAB_W-1:0] eqLabelB
);
  logic             rdFg, rdStart, recFg, recStart;
  logic [LAB_W-1:0] rdLabel, trackLabel, lastLabel, curPrevLabel;
  logic [LAB_W-1:0] baseLast, lastNext, newCnt, labUse;
  logic             ovSeen, baseOv, ovNext, overlapNow, eqNow, evTrig;
  logic [COL_W-1:0] runHead, headCol;
  logic [CNT_W-1:0] accCnt, accCntNext;
  logic [SC_W-1:0]  accCol, accColNext;
  logic [SR_W-1:0]  accRow, accRowNext;

  row_record #(.COLS(COLS), .LAB_W(LAB_W)) u_rec (
    .clk(clk), .rstN(rstN),
    .rdBank(~strb.bank), .rdCol(colIdx),
    .rdFg(rdFg), .rdStart(rdStart), .rdLabel(rdLabel),
    .pixWe(strb.act), .wrBank(strb.bank), .wrCol(colIdx),
    .wrFg(strb.fg), .wrStart(strb.runBegin),
    .labWe(evTrig), .labCol(headCol), .labVal(labUse)
  );

  // The row above does not exist for row 0.
  assign recFg    = rdFg & ~strb.firstRow;
  assign recStart = rdStart & ~strb.firstRow;

  always_comb begin
    overlapNow   = strb.fg & recFg;
    curPrevLabel = recStart ? rdLabel : trackLabel;
    baseOv       = strb.runInside ? ovSeen : 1'b0;
    baseLast     = strb.runInside ? lastLabel : '0;
    ovNext       = baseOv | overlapNow;
    lastNext     = overlapNow ? curPrevLabel : baseLast;
    eqNow        = strb.runInside & recStart & ovSeen;
    evTrig       = strb.tailAfter | strb.edgeEnd;
    labUse       = strb.lineStart ? LAB_W'(1) : newCnt;
    headCol      = strb.runBegin ? colIdx : runHead;
    if (strb.runBegin) begin
      accCntNext = CNT_W'(1);
      accColNext = SC_W'(colIdx);
      accRowNext = SR_W'(rowIdx);
    end else begin
      accCntNext = accCnt + 1'b1;
      accColNext = accCol + SC_W'(colIdx);
      accRowNext = accRow + SR_W'(rowIdx);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accCnt <= '0; accCol <= '0; accRow <= '0;
      ovSeen <= 1'b0; lastLabel <= '0; runHead <= '0;
      trackLabel <= '0; newCnt <= LAB_W'(1);
    end else if (strb.act) begin
      if (strb.fg) begin
        accCnt    <= accCntNext;
        accCol    <= accColNext;
        accRow    <= accRowNext;
        ovSeen    <= ovNext;
        lastLabel <= lastNext;
        if (strb.runBegin) runHead <= colIdx;
      end
      if (recStart) trackLabel <= rdLabel;
      newCnt <= labUse + LAB_W'(evTrig);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evValid <= 1'b0; evCount <= '0; evSumCol <= '0; evSumRow <= '0;
      evOverlap <= 1'b0; evPrevLabel <= '0; evLabel <= '0;
      eqValid <= 1'b0; eqLabelA <= '0; eqLabelB <= '0;
    end else begin
      evValid <= evTrig;
      eqValid <= eqNow;
      if (evTrig) begin
        evLabel <= labUse;
        if (strb.edgeEnd) begin
          evCount <= accCntNext; evSumCol <= accColNext; evSumRow <= accRowNext;
          evOverlap <= ovNext; evPrevLabel <= lastNext;
        end else begin
          evCount <= accCnt; evSumCol <= accCol; evSumRow <= accRow;
          evOverlap <= ovSeen; evPrevLabel <= lastLabel;
        end
      end
      if (eqNow) begin
        eqLabelA <= lastLabel;
        eqLabelB <= rdLabel;
      end
    end
  end

  assert_count_nonzero_R2: assert property (@(posedge clk) disable iff (!rstN)
    evValid |-> (evCount != '0) && (evCount <= CNT_W'(COLS)));

  assert_prev_label_R5: assert property (@(posedge clk) disable iff (!rstN)
    evValid |-> (evOverlap ? (evPrevLabel != '0) : (evPrevLabel == '0)));

  assert_label_range_R6: assert property (@(posedge clk) disable iff (!rstN)
    evValid |-> (evLabel != '0) && (evLabel <= LAB_W'(COLS / 2)));

  assert_eq_distinct_R7: assert property (@(posedge clk) disable iff (!rstN)
    eqValid |-> (eqLabelA != '0) && (eqLabelB != '0) && (eqLabelA != eqLabelB));

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strb.act |=> !evValid && !eqValid);
endmodule

// File: rtl/run_scanner.sv
module run_scanner
  import scan_pkg::*;
#(
  parameter int COLS = 16,
  parameter int ROWS = 16,
  localparam int COL_W = $clog2(COLS),
  localparam int ROW_W = $clog2(ROWS),
  localparam int LAB_W = $clog2(COLS / 2 + 1),
  localparam int CNT_W = $clog2(COLS + 1),
  localparam int SC_W  = $clog2(COLS * (COLS - 1) / 2 + 1),
  localparam int SR_W  = $clog2(COLS * (ROWS - 1) + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pixValid,
  input  logic             pixData,
  input  logic             lineStart,
  input  logic             frameStart,
  output logic             evValid,
  output logic [CNT_W-1:0] evCount,
  output logic [SC_W-1:0]  evSumCol,
  output logic [SR_W-1:0]  evSumRow,
  output logic             evOverlap,
  output logic [LAB_W-1:0] evPrevLabel,
  output logic [LAB_W-1:0] evLabel,
  output logic             eqValid,
  output logic [LAB_W-1:0] eqLabelA,
  output logic [LAB_W-1:0] eqLabelB
);
  scanStrobe_t      strb;
  logic [COL_W-1:0] colIdx;
  logic [ROW_W-1:0] rowIdx;

  scan_ctrl #(.COLS(COLS), .ROWS(ROWS)) u_ctrl (
    .clk(clk), .rstN(rstN), .pixValid(pixValid), .pixData(pixData),
    .lineStart(lineStart), .frameStart(frameStart),
    .strb(strb), .colIdx(colIdx), .rowIdx(rowIdx)
  );

  scan_datapath #(.COLS(COLS), .ROWS(ROWS)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .colIdx(colIdx), .rowIdx(rowIdx),
    .evValid(evValid), .evCount(evCount), .evSumCol(evSumCol),
    .evSumRow(evSumRow), .evOverlap(evOverlap), .evPrevLabel(evPrevLabel),
    .evLabel(evLabel), .eqValid(eqValid), .eqLabelA(eqLabelA), .eqLabelB(eqLabelB)
  );
endmodule

// File: tb/run_scanner_tb.sv
module run_scanner_tb;
  localparam int COLS = 16;
  localparam int ROWS = 16;

  logic clk = 1'b0, rstN = 1'b0;
  logic pixValid = 1'b0, pixData = 1'b0, lineStart = 1'b0, frameStart = 1'b0;
  logic evValid, evOverlap, eqValid;
  logic [4:0] evCount;
  logic [6:0] evSumCol;
  logic [7:0] evSumRow;
  logic [3:0] evPrevLabel, evLabel, eqLabelA, eqLabelB;

  run_scanner #(.COLS(COLS), .ROWS(ROWS)) u_dut (.*);

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  bit img [ROWS][COLS];
  int labRow [ROWS][COLS];
  bit evE [ROWS][COLS];
  int eCnt [ROWS][COLS], eSc [ROWS][COLS], eSr [ROWS][COLS];
  int eOv [ROWS][COLS], ePrev [ROWS][COLS], eLab [ROWS][COLS];
  bit qE [ROWS][COLS];
  int qA [ROWS][COLS], qB [ROWS][COLS];
  bit havePrev = 0, pIdle = 0;
  int pr = 0, px = 0;

  task automatic chk(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Run-level model of the requirements.
  task automatic computeExpected();
    for (int r = 0; r < ROWS; r++) begin
      for (int c = 0; c < COLS; c++) begin
        evE[r][c] = 0; qE[r][c] = 0; labRow[r][c] = 0;
      end
    end
    for (int r = 0; r < ROWS; r++) begin
      int k = 0;
      int x = 0;
      while (x < COLS) begin
        if (img[r][x]) begin
          int s = x, e, ex, sc = 0, ov = 0, last = 0;
          while (x < COLS && img[r][x]) x++;
          e = x - 1;
          k++;
          for (int c = s; c <= e; c++) begin
            sc += c;
            labRow[r][c] = k;
            if (r > 0 && img[r-1][c]) begin
              bit pst = (c == 0) || !img[r-1][c-1];
              if (c > s && ov == 1 && pst) begin
                qE[r][c] = 1; qA[r][c] = last; qB[r][c] = labRow[r-1][c];
              end
              ov = 1;
              last = labRow[r-1][c];
            end
          end
          ex = (e == COLS - 1) ? e : e + 1;
          evE[r][ex] = 1; eCnt[r][ex] = e - s + 1; eSc[r][ex] = sc;
          eSr[r][ex] = r * (e - s + 1); eOv[r][ex] = ov; ePrev[r][ex] = last;
          eLab[r][ex] = k;
        end else x++;
      end
    end
  endtask

  // Compares outputs with what the previously driven pixel predicts.
  task automatic checkPrev();
    if (!havePrev) return;
    if (pIdle) begin
      chk("R8", int'(evValid), 0, "evValid after idle clock");
      chk("R8", int'(eqValid), 0, "eqValid after idle clock");
    end else begin
      string tg = (px == COLS - 1) ? "R3" : "R1";
      chk(tg, int'(evValid), int'(evE[pr][px]), $sformatf("evValid r%0d c%0d", pr, px));
      if (evValid && evE[pr][px]) begin
        chk("R2", int'(evCount), eCnt[pr][px], "evCount");
        chk("R2", int'(evSumCol), eSc[pr][px], "evSumCol");
        chk("R10", int'(evSumRow), eSr[pr][px], "evSumRow");
        chk("R4", int'(evOverlap), eOv[pr][px], "evOverlap");
        chk("R5", int'(evPrevLabel), ePrev[pr][px], "evPrevLabel");
        chk("R6", int'(evLabel), eLab[pr][px], "evLabel");
      end
      chk("R7", int'(eqValid), int'(qE[pr][px]), $sformatf("eqValid r%0d c%0d", pr, px));
      if (eqValid && qE[pr][px]) begin
        chk("R7", int'(eqLabelA), qA[pr][px], "eqLabelA");
        chk("R7", int'(eqLabelB), qB[pr][px], "eqLabelB");
      end
    end
  endtask

  task automatic stepPix(bit v, int r, int x);
    @(negedge clk);
    checkPrev();
    pixValid   = v;
    pixData    = v ? img[r][x] : 1'b0;
    lineStart  = v && (x == 0);
    frameStart = v && (x == 0) && (r == 0);
    pr = r; px = x; pIdle = !v; havePrev = 1;
  endtask

  task automatic playFrame(bit gaps);
    computeExpected();
    for (int r = 0; r < ROWS; r++)
      for (int x = 0; x < COLS; x++) begin
        if (gaps && ($urandom % 5 == 0)) stepPix(0, r, x);
        stepPix(1, r, x);
      end
    stepPix(0, 0, 0);
  endtask

  task automatic fillFrame(int mode);
    for (int r = 0; r < ROWS; r++)
      for (int x = 0; x < COLS; x++)
        case (mode)
          0: img[r][x] = 0;
          1: img[r][x] = 1;
          2: img[r][x] = (x % 2 == 1);
          3: img[r][x] = (r % 3 == 0) ? ((x % 4) != 3) : ((r % 3 == 1) ? (x < 14) : 0);
          4: img[r][x] = ((x + r) % 5 < 2);
          default: img[r][x] = ($urandom % 100) < 45;
        endcase
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7331));
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    @(negedge clk);
    chk("R9", int'(evValid), 0, "evValid after reset");
    chk("R9", int'(eqValid), 0, "eqValid after reset");
    for (int m = 0; m < 5; m++) begin   // directed: empty, full edge runs, max labels, equivalence, diagonal
      fillFrame(m);
      playFrame(0);
    end
    for (int n = 0; n < 6; n++) begin   // random frames, half with idle clocks (R8)
      fillFrame(9);
      playFrame(n % 2 == 1);
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule